// File: doc/BRIEF.md
# Microcoded ALU-Shifter Datapath

This block is the execution half of a microprogrammed machine. Each clock cycle it receives one control word, split into four independent fields: one chooses what drives a shared operand bus, one picks the ALU operation, one configures a programmable shifter behind the ALU, and one names the storage element that captures the shifter output at the end of the cycle. Storage is eight 16-bit general registers plus an accumulator. The bus can also carry an external input port or the constant taken from the address field of the control word.

The shifter output and its two flags (carry and zero) are combinational within the cycle. An external sequencer uses the flags to take conditional jumps in the same cycle. The sequencer itself sits outside this block.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, all eight general registers and the accumulator are cleared to 0.
- R2: Operand bus select: codes 0 to 7 read general register 0 to 7. Code 8 reads `data_in`. Code 9 reads `const_in`. Codes 10 to 15 drive 0.
- R3: ALU op codes: 0 gives ACC, 1 gives bus, 2 gives ACC+bus, 3 gives ACC-bus, 4 gives bus-ACC, 5 gives ACC AND bus, 6 gives ACC OR bus, 7 gives NOT bus, 8 gives bus+1, 9 gives ACC+1, 10 gives 0, 11 gives 1. Codes 12 to 15 give 0. All arithmetic wraps modulo 2^16.
- R4: The ALU carry is the carry out of the 16-bit sum for codes 2, 8 and 9. For codes 3 and 4 it is the borrow, which is 1 when the unsigned minuend is smaller than the subtrahend. For every other code it is 0.
- R5: Shifter codes act on the ALU result X:
  - 0 and 4 give X<<1, with carry = X[15].
  - 1 gives a logical X>>1, with carry = X[0].
  - 2 rotates left, with carry = X[15].
  - 3 rotates right, with carry = X[0].
  - 5 gives an arithmetic right shift that keeps bit 15, with carry = X[0].
- R6: Shifter codes 7 and 6 pass X through unchanged. In that case `carry` is the ALU carry of R4.
- R7: `zero` is 1 exactly when `result` is all zeros.
- R8: Destination codes 0 to 7 write `result` into general register 0 to 7, and code 8 writes it into the accumulator. The write happens at the rising clock edge that ends the cycle, so a read in the following cycle returns the new value.
- R9: Destination codes 9 to 15 write nothing. Every register and the accumulator keep their values.
- R10: When the block is driven with the subtract-and-compare GCD microprogram on inputs a, b (1 to 32767), general register 0 ends holding GCD(a, b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 4 | Operand bus source code |
| alu_op | input | 4 | ALU operation code |
| shf_op | input | 3 | Shifter function code |
| dst_sel | input | 4 | Write destination code |
| const_in | input | 16 | Constant from the control word address field |
| data_in | input | 16 | External input port |
| result | output | 16 | Shifter output, written to the destination |
| carry | output | 1 | Bit shifted out, or ALU carry/borrow in pass-through |
| zero | output | 1 | Shifter output is zero |

## Verification
The bench goes after the following corner cases:
- **Borrow direction on both subtractions.** An inverted borrow would send the GCD program down the wrong branch.
- **The bit that leaves on each shift and rotate.** A mixed-up end would give a wrong carry on shifts of odd or negative values.
- **Sign fill on the arithmetic right shift.** A zero-filling version fails on negative operands.
- **Carry out of 0xFFFF+1 and ACC+1.** Dropping the 17th bit loses the carry.
- **Unused bus, ALU and destination codes.** A design that decoded them loosely would produce stray values or corrupt a register.

Write-then-read in consecutive cycles catches a design whose register becomes visible one cycle late. The GCD runs, including equal inputs and coprime inputs, exercise all of these together through the flag-driven loop.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] bus_sel,
  input  logic [3:0]      alu_op,
  input  logic [2:0]      shf_op,
  input  logic [SELW-1:0] dst_sel,
  input  logic [W-1:0]    const_in,
  input  logic [W-1:0]    data_in,
  output logic [W-1:0]    result,
  output logic            carry,
  output logic            zero
);
  localparam int IW = $clog2(NREG);
  localparam logic [SELW-1:0] SEL_NREG = SELW'(NREG);
  localparam logic [SELW-1:0] SEL_IN   = SELW'(NREG);
  localparam logic [SELW-1:0] SEL_K    = SELW'(NREG + 1);

  logic [W-1:0] rf [NREG];
  logic [W-1:0] acc;
  logic [W-1:0] bus;
  logic [W:0]   alu;

  always_comb begin
    if (bus_sel < SEL_NREG)   bus = rf[bus_sel[IW-1:0]];
    else if (bus_sel == SEL_IN) bus = data_in;
    else if (bus_sel == SEL_K)  bus = const_in;
    else                        bus = '0;
  end

  always_comb begin
    case (alu_op)
      4'h0:    alu = {1'b0, acc};
      4'h1:    alu = {1'b0, bus};
      4'h2:    alu = {1'b0, acc} + {1'b0, bus};
      4'h3:    alu = {1'b0, acc} - {1'b0, bus};
      4'h4:    alu = {1'b0, bus} - {1'b0, acc};
      4'h5:    alu = {1'b0, acc & bus};
      4'h6:    alu = {1'b0, acc | bus};
      4'h7:    alu = {1'b0, ~bus};
      4'h8:    alu = {1'b0, bus} + (W+1)'(1);
      4'h9:    alu = {1'b0, acc} + (W+1)'(1);
      4'hB:    alu = (W+1)'(1);
      default: alu = '0;
    endcase
  end

  wire [W-1:0] x = alu[W-1:0];

  always_comb begin
    case (shf_op)
      3'b000, 3'b100: {carry, result} = {x[W-1], x[W-2:0], 1'b0};
      3'b001:         {carry, result} = {x[0], 1'b0, x[W-1:1]};
      3'b010:         {carry, result} = {x[W-1], x[W-2:0], x[W-1]};
      3'b011:         {carry, result} = {x[0], x[0], x[W-1:1]};
      3'b101:         {carry, result} = {x[0], x[W-1], x[W-1:1]};
      default:        {carry, result} = {alu[W], x};
    endcase
  end

  assign zero = (result == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      acc <= '0;
    end else if (dst_sel < SEL_NREG) begin
      rf[dst_sel[IW-1:0]] <= result;
    end else if (dst_sel == SEL_NREG) begin
      acc <= result;
    end
  end
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   bus_sel,
  input logic [3:0]   alu_op,
  input logic [2:0]   shf_op,
  input logic [3:0]   dst_sel,
  input logic [W-1:0] data_in,
  input logic [W-1:0] result,
  input logic         carry,
  input logic         zero
);
  wire readout = (alu_op == 4'h1) && (shf_op == 3'b111) && (dst_sel == 4'hF);

  a_r2_input_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 4'h8 && alu_op == 4'h1 && shf_op == 3'b111) |-> (result == data_in && !carry));

  a_r3_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 4'hA && shf_op == 3'b111) |-> (result == '0 && zero && !carry));

  a_r5_lsl_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_op == 3'b000) |-> (result[0] == 1'b0));

  a_r5_asr_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_op == 3'b101) |-> (result[W-1] == result[W-2]));

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> (result == '0));

  a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == 4'h3) |=> (!(bus_sel == 4'h3 && readout) || result == $past(result)));

  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel >= 4'h9 && bus_sel < 4'h8 && readout) |=>
      (!(bus_sel == $past(bus_sel) && readout) || result == $past(result)));
endmodule

bind mc_datapath mc_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .alu_op(alu_op),
  .shf_op(shf_op), .dst_sel(dst_sel), .data_in(data_in),
  .result(result), .carry(carry), .zero(zero)
);

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_sel = 4'hF, alu_op = 4'hA, dst_sel = 4'hF;
  logic [2:0] shf_op = 3'b111;
  logic [15:0] const_in = 0, data_in = 0;
  logic [15:0] result;
  logic carry, zero;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_rf [8];
  logic [15:0] m_acc;
  logic got_c, got_z;
  logic [15:0] got_r;

  mc_datapath uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .alu_op(alu_op),
    .shf_op(shf_op), .dst_sel(dst_sel), .const_in(const_in), .data_in(data_in),
    .result(result), .carry(carry), .zero(zero));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] f_bus(logic [3:0] s, logic [15:0] k, logic [15:0] d);
    if (s < 8) return m_rf[s[2:0]];
    if (s == 8) return d;
    if (s == 9) return k;
    return 16'h0;
  endfunction

  function automatic logic [16:0] f_alu(logic [3:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return {1'b0, a};
      1: return {1'b0, b};
      2: return {1'b0, a} + {1'b0, b};
      3: return {(a < b), a - b};
      4: return {(b < a), b - a};
      5: return {1'b0, a & b};
      6: return {1'b0, a | b};
      7: return {1'b0, ~b};
      8: return {1'b0, b} + 17'd1;
      9: return {1'b0, a} + 17'd1;
      11: return 17'd1;
      default: return 17'd0;
    endcase
  endfunction

  function automatic logic [16:0] f_shf(logic [2:0] op, logic [16:0] ax);
    logic [15:0] x = ax[15:0];
    case (op)
      0, 4: return {x[15], x << 1};
      1: return {x[0], x >> 1};
      2: return {x[15], x[14:0], x[15]};
      3: return {x[0], x[0], x[15:1]};
      5: return {x[0], $signed(x) >>> 1};
      default: return ax;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] b, logic [3:0] a, logic [2:0] s,
                      logic [3:0] d, logic [15:0] k, logic [15:0] x);
    logic [16:0] e;
    @(negedge clk);
    bus_sel = b; alu_op = a; shf_op = s; dst_sel = d; const_in = k; data_in = x;
    #1;
    e = f_shf(s, f_alu(a, m_acc, f_bus(b, k, x)));
    got_r = result; got_c = carry; got_z = zero;
    check(tag, {13'd0, zero, carry, result}, {13'd0, (e[15:0] == 0), e[16], e[15:0]});
    @(posedge clk);
    if (d < 8) m_rf[d[2:0]] = e[15:0];
    else if (d == 8) m_acc = e[15:0];
  endtask

  function automatic int gcd(int a, int b);
    while (b != 0) begin int t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic run_gcd(logic [15:0] a, logic [15:0] b);
    int pc = 0, guard = 0;
    while (pc != 6 && guard < 20000) begin
      guard++;
      case (pc)
        0: begin step("R10 load", 8, 1, 7, 0, 0, a); pc = 1; end
        1: begin step("R10 load", 8, 1, 7, 8, 0, b); pc = 2; end
        2: begin step("R10 cmp", 0, 4, 7, 15, 0, 0); pc = got_z ? 6 : 3; end
        3: begin step("R10 sign", 0, 4, 0, 15, 0, 0); pc = got_c ? 5 : 4; end
        4: begin step("R10 sub", 0, 4, 7, 0, 0, 0); pc = 2; end
        default: begin step("R10 sub", 0, 3, 7, 8, 0, 0); pc = 2; end
      endcase
    end
    step("R10 readout", 0, 1, 7, 15, 0, 0);
    check("R10 gcd", {16'd0, got_r}, 32'(gcd(a, b)));
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) m_rf[i] = 16'hDEAD;
    m_acc = 16'hDEAD;
    #(PERIOD * 3);
    for (int i = 0; i < 8; i++) m_rf[i] = 0;
    m_acc = 0;
    rst_n = 1;

    // R1: reset state of every register and the accumulator
    for (int i = 0; i < 8; i++) step("R1 reg", 4'(i), 1, 7, 15, 0, 0);
    step("R1 acc", 0, 0, 7, 15, 0, 0);

    // R2: bus sources, then R8 write and immediate readback
    step("R2 const", 9, 1, 7, 8, 16'h1234, 16'h0);
    step("R8 acc read", 0, 0, 7, 15, 0, 0);
    check("R8 acc", {16'd0, got_r}, 32'h1234);
    for (int i = 0; i < 8; i++) step("R8 write", 8, 1, 7, 4'(i), 0, 16'(16'h0101 * (i + 1)));
    for (int i = 0; i < 8; i++) begin
      step("R2 read", 4'(i), 1, 7, 15, 0, 0);
      check("R2 reg", {16'd0, got_r}, 32'(16'h0101 * (i + 1)));
    end
    step("R2 unused", 4'hC, 1, 7, 15, 16'hFFFF, 16'hFFFF);
    check("R2 unused", {16'd0, got_r}, 0);

    // R4: borrow direction and carry out
    step("R4 acc", 9, 1, 7, 8, 16'd5, 0);
    step("R4 acc-bus", 9, 3, 7, 15, 16'd7, 0);
    check("R4 borrow", {31'd0, got_c}, 1);
    step("R4 bus-acc", 9, 4, 7, 15, 16'd7, 0);
    check("R4 no borrow", {31'd0, got_c}, 0);
    step("R4 inc", 9, 8, 7, 15, 16'hFFFF, 0);
    check("R4 inc carry", {15'd0, got_c, got_r}, 32'h10000);

    // R5: shift/rotate end bits; R6: code 110 pass-through
    step("R5 asr", 9, 1, 5, 15, 16'h8001, 0);
    check("R5 asr", {15'd0, got_c, got_r}, 32'h1C000);
    step("R5 ror", 9, 1, 3, 15, 16'h0001, 0);
    check("R5 ror", {15'd0, got_c, got_r}, 32'h18000);
    step("R5 lsr", 9, 1, 1, 15, 16'h8001, 0);
    check("R5 lsr", {15'd0, got_c, got_r}, 32'h14000);
    step("R6 pass110", 9, 2, 6, 15, 16'hFFFF, 0);
    check("R6 pass110", {15'd0, got_c, got_r}, 32'h10004);

    // R3 R7: constants and zero flag
    step("R3 one", 0, 11, 7, 15, 0, 0);
    check("R3 one", {15'd0, got_z, got_r}, 1);
    step("R7 zero", 0, 13, 7, 15, 0, 0);
    check("R7 unused op", {15'd0, got_z, got_r}, 32'h10000);

    // R9: unused destinations leave every register intact
    for (int d = 9; d < 16; d++) step("R9 nowrite", 9, 1, 7, 4'(d), 16'hBEEF, 0);
    for (int i = 0; i < 8; i++) step("R9 keep", 4'(i), 1, 7, 15, 0, 0);
    step("R9 acc keep", 0, 0, 7, 15, 0, 0);

    // Constrained random mix, R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 3000; i++)
      step("R3 R5 R8 random", 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
           3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
           16'($urandom), 16'($urandom));

    // R10: GCD microprogram
    run_gcd(16'd48, 16'd18);
    run_gcd(16'd77, 16'd77);
    run_gcd(16'd1, 16'd900);
    run_gcd(16'd1024, 16'd999);
    for (int i = 0; i < 4; i++)
      run_gcd(16'($urandom_range(1, 1500)), 16'($urandom_range(1, 1500)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule